// File: doc/BRIEF.md
# Bus-Overridable 16-Pin GPIO Port

A sixteen-pin general-purpose I/O port split into two byte lanes. Software programs each lane's pin direction and output value through a small byte-wide register interface. A clocked two-stage synchronizer brings the pin levels in, and software reads them back through the same interface.

When the external-bus enable is high, every pin is forced to drive, and each pin carries the matching bit of a 16-bit alternate address word. The output register no longer reaches the pins in this mode. The software-programmed direction and output values are kept untouched. They govern the pins again on the first cycle after the bus enable drops.

The synchronized levels of the four topmost pins also leave the block as capture taps for a neighbouring timer unit.

Top module: `gpio16_busport`

## Requirements
- R1: After reset, all output enables and output values are 0, the bus-write flag is 0, and both direction registers read back as 0.
- R2: A write with `reg_addr` 2 (low lane) or 3 (high lane) loads that lane's direction bits. A direction bit of 1 makes the pin an output. The new value appears on `pin_oe` in the cycle after the write edge, and the other lane is unchanged.
- R3: A write with `reg_addr` 0 (low lane) or 1 (high lane) loads that lane's output bits. While bus mode is off, these bits appear on `pin_out` in the cycle after the write edge, and the other lane is unchanged.
- R4: While `bus_en` is 1, every bit of `pin_oe` is 1, whatever the stored direction bits are.
- R5: While `bus_en` is 1, `pin_out` bit n equals `bus_addr` bit n for all sixteen pins.
- R6: The direction and output registers keep their stored values through bus mode. Direction reads return the stored bits, not the forced value. The stored values drive the pins again as soon as `bus_en` is 0.
- R7: A read with `reg_addr` 0 or 1 returns that lane's pin levels through a two-flop synchronizer. A change on `pin_in` is visible in `reg_rdata` after the second rising edge and not after the first.
- R8: `cap_tap[k]` equals the synchronized level of pin 12+k, for k from 0 to 3.
- R9: An output-register write while `bus_en` is 1 is stored, and it sets `bus_wr_flag` on that edge. An output-register write while `bus_en` is 0 clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0/1 output low/high, 2/3 direction low/high |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for `reg_addr` |
| bus_en | input | 1 | External-bus override enable |
| bus_addr | input | 16 | Alternate address word driven in bus mode |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables, 1 = drive |
| cap_tap | output | 4 | Synchronized levels of pins 12 to 15 |
| bus_wr_flag | output | 1 | Set by an output-register write during bus mode |

## Verification
The bench writes patterns into one lane and checks that the other lane stays put. A design with a byte-select or part-select slip would corrupt the neighbouring byte.

It programs a sparse direction mask, enters bus mode, and writes the output register while the override is active. It then checks that the pins follow the address word and that the direction readback still shows the sparse mask. It also checks that the mask and the new output value return on exit. A design that overwrote the stored state, or read back the forced value, fails here.

Input changes are checked one edge and two edges after they arrive. This catches a synchronizer that is one stage short or one stage long. It also catches capture taps taken from the wrong pins.

// File: rtl/gpio16_busport.sv
module gpio16_busport #(
  parameter int PW = 16,
  parameter int BW = 8,
  parameter int NTAP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [BW-1:0] reg_wdata,
  output logic [BW-1:0] reg_rdata,
  input  logic          bus_en,
  input  logic [PW-1:0] bus_addr,
  input  logic [PW-1:0] pin_in,
  output logic [PW-1:0] pin_out,
  output logic [PW-1:0] pin_oe,
  output logic [NTAP-1:0] cap_tap,
  output logic          bus_wr_flag
);
  localparam int NL = PW / BW;

  logic [PW-1:0] dir_q, dat_q, sync1_q, sync2_q;
  logic is_dir, lane;
  logic [1:0] age_q;

  assign is_dir = reg_addr[1];
  assign lane   = reg_addr[0];

  for (genvar g = 0; g < NL; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q[g*BW +: BW] <= '0;
        dat_q[g*BW +: BW] <= '0;
      end else if (reg_wr && (lane == 1'(g))) begin
        if (is_dir) dir_q[g*BW +: BW] <= reg_wdata;
        else        dat_q[g*BW +: BW] <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q     <= '0;
      sync2_q     <= '0;
      bus_wr_flag <= 1'b0;
      age_q       <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (reg_wr && !is_dir) bus_wr_flag <= bus_en;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  assign pin_oe    = bus_en ? {PW{1'b1}} : dir_q;
  assign pin_out   = bus_en ? bus_addr : dat_q;
  assign reg_rdata = is_dir ? dir_q[lane*BW +: BW] : sync2_q[lane*BW +: BW];
  assign cap_tap   = sync2_q[PW-1 -: NTAP];

  p_dir_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) ##1 !bus_en |-> pin_oe[BW-1:0] == $past(reg_wdata));
  p_dat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) ##1 !bus_en |-> pin_out[PW-1:BW] == $past(reg_wdata));
  p_bus_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> &pin_oe);
  p_bus_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> pin_out == bus_addr);
  p_dir_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !(reg_wr && is_dir)) |=> $stable(dir_q));
  p_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> cap_tap == $past(pin_in[PW-1 -: NTAP], 2));
  p_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !is_dir && bus_en) |=> bus_wr_flag);
endmodule

// File: tb/gpio16_busport_tb_top.sv
module gpio16_busport_tb_top;
  logic clk = 0, rst_n = 0, reg_wr = 0, bus_en = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [15:0] bus_addr = 0, pin_in = 0, pin_out, pin_oe;
  logic [3:0] cap_tap;
  logic bus_wr_flag;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  gpio16_busport dut_i (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .bus_en, .bus_addr, .pin_in, .pin_out, .pin_oe, .cap_tap, .bus_wr_flag);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 oe", pin_oe, 16'h0);
    chk("R1 out", pin_out, 16'h0);
    chk("R1 flag", {15'b0, bus_wr_flag}, 16'h0);
    rd(2'd2, d); chk("R1 dirlo", {8'h0, d}, 16'h0);
    rd(2'd3, d); chk("R1 dirhi", {8'h0, d}, 16'h0);
  endtask

  task automatic t_lanes;
    logic [7:0] d;
    wr(2'd2, 8'hA5); chk("R2 dirlo", pin_oe, 16'h00A5);
    wr(2'd3, 8'h3C); chk("R2 dirhi", pin_oe, 16'h3CA5);
    wr(2'd0, 8'h5A); chk("R3 datlo", pin_out, 16'h005A);
    wr(2'd1, 8'hF0); chk("R3 dathi", pin_out, 16'hF05A);
    wr(2'd0, 8'h81); chk("R3 lo only", pin_out, 16'hF081);
    rd(2'd3, d); chk("R2 readback", {8'h0, d}, 16'h003C);
  endtask

  task automatic t_bus;
    logic [7:0] d;
    @(negedge clk); bus_en = 1; bus_addr = 16'h1234; #1;
    chk("R4 oe", pin_oe, 16'hFFFF);
    chk("R5 out", pin_out, 16'h1234);
    bus_addr = 16'hBEEF; #1;
    chk("R5 out2", pin_out, 16'hBEEF);
    wr(2'd1, 8'h77);
    chk("R9 flag set", {15'b0, bus_wr_flag}, 16'h1);
    chk("R5 ignore dat", pin_out, 16'hBEEF);
    rd(2'd2, d); chk("R6 dir stored", {8'h0, d}, 16'h00A5);
    @(negedge clk); bus_en = 0; #1;
    chk("R6 oe restore", pin_oe, 16'h3CA5);
    chk("R6 out restore", pin_out, 16'h7781);
    chk("R9 flag holds", {15'b0, bus_wr_flag}, 16'h1);
    wr(2'd0, 8'h00);
    chk("R9 flag clear", {15'b0, bus_wr_flag}, 16'h0);
  endtask

  task automatic t_sync;
    logic [7:0] d;
    @(negedge clk); pin_in = 16'hC3E7;
    @(negedge clk);
    rd(2'd0, d); chk("R7 one edge", {8'h0, d}, 16'h0);
    chk("R8 one edge", {12'h0, cap_tap}, 16'h0);
    @(negedge clk);
    rd(2'd0, d); chk("R7 lo", {8'h0, d}, 16'h00E7);
    rd(2'd1, d); chk("R7 hi", {8'h0, d}, 16'h00C3);
    chk("R8 taps", {12'h0, cap_tap}, 16'h000C);
    pin_in = 16'h5000;
    repeat (2) @(negedge clk);
    chk("R8 taps2", {12'h0, cap_tap}, 16'h0005);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_lanes;
    t_bus;
    t_sync;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule